// File: doc/BRIEF.md
# I2S to Simultaneous-Mode DAC Formatter

This block takes a standard I2S stream (serial data, word select and bit clock) and reshapes it for a 16-bit stereo DAC that expects both channels in parallel. The DAC side has four lines: one serial data line per channel, one shared gated bit clock, and a latch strobe. The block runs in a fast system clock domain. It oversamples the three I2S lines and acts on the edges of the incoming bit clock.

On the receive side, each sample's sign bit is flipped as it arrives, so a two's-complement sample becomes offset binary. The left word is held until the matching right word has been collected. The pair then passes to a transmit state machine. That machine shifts both words out MSB first on the two data lines under one gated clock that runs for exactly 16 cycles. It then raises the latch strobe so the DAC updates both outputs at once.

The transmit machine has three states. TX_IDLE holds the clock and strobe high. The transition IDLE→SHIFT is taken when a completed pair is handed over. TX_SHIFT pulls the strobe low and sends one bit per input bit-clock period. The transition SHIFT→LATCH is taken once the sixteenth bit has been clocked out and the gated clock is low. TX_LATCH raises the strobe. The transition LATCH→IDLE is taken on the next input bit-clock rising edge, which also restores the gated clock to high.

Top module: `i2s_simul_fmt`

## Requirements
- R1: After reset the gated clock and the latch strobe are high and both DAC data lines are low.
- R2: The word the DAC receives on each channel equals the I2S sample with bit 15 inverted, i.e. sample XOR 0x8000.
- R3: The left and right words of one I2S frame are shifted out together, one bit on each line per gated clock cycle, and are latched by the same strobe edge.
- R4: Each latch strobe low window contains exactly 16 falling edges of the gated clock. The gated clock never falls while the strobe is high, and it is high when the strobe falls.
- R5: The DAC data lines change only while the gated clock is high and the strobe is low, so that they are stable at each falling edge.
- R6: The strobe rises only after the sixteenth bit has been clocked in. It stays high for at least one input bit-clock period before the next window opens.
- R7: Bits beyond the sixteenth within a word-select slot are ignored. The slot may be 16, 24 or 32 bit clocks long.
- R8: Word select low marks the left channel. The MSB is the bit sampled on the second rising edge of the bit clock after a word-select change, and bits are taken on rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the I2S bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bck_i | input | 1 | I2S bit clock |
| ws_i | input | 1 | I2S word select, low for left |
| sd_i | input | 1 | I2S serial data, MSB first |
| dac_bck_o | output | 1 | Gated bit clock to the DAC; the DAC samples on its falling edge |
| dac_le_o | output | 1 | Latch strobe; the DAC updates on its rising edge |
| dac_dl_o | output | 1 | Left-channel serial data, offset binary, MSB first |
| dac_dr_o | output | 1 | Right-channel serial data, offset binary, MSB first |

## Verification
The assertions rely on three conditions. Each phase of the input bit clock lasts at least two system clocks. Every word-select slot carries at least 16 bits. Word select and data change only near the falling edge of the bit clock. Without these conditions, the handover and the 16-bit window could overlap. The stimulus drives the bit clock with four system clocks per phase and changes word select and data together with its falling edge. It picks slot lengths only from 16, 24 and 32, so every pair reaches the transmit machine while the machine is idle.

// File: rtl/i2s_simul_pkg.sv
package i2s_simul_pkg;
    localparam int SAMPLE_W = 16;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_SHIFT = 2'd1,
        TX_LATCH = 2'd2
    } tx_state_t;
endpackage

// File: rtl/i2s_simul_sync.sv
module i2s_simul_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bck_i,
    input  logic ws_i,
    input  logic sd_i,
    output logic bck_rise_o,
    output logic bck_fall_o,
    output logic ws_o,
    output logic sd_o
);
    localparam int LAST = STAGES - 1;

    // bit 2: bit clock, bit 1: word select, bit 0: data
    logic [2:0] stg_q [STAGES];
    logic       bck_d_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= 3'b110;
            end
            bck_d_q <= 1'b1;
        end else begin
            stg_q[0] <= {bck_i, ws_i, sd_i};
            for (int i = 1; i < STAGES; i++) begin
                stg_q[i] <= stg_q[i-1];
            end
            bck_d_q <= stg_q[LAST][2];
        end
    end

    assign bck_rise_o = stg_q[LAST][2] & ~bck_d_q;
    assign bck_fall_o = ~stg_q[LAST][2] & bck_d_q;
    assign ws_o       = stg_q[LAST][1];
    assign sd_o       = stg_q[LAST][0];

endmodule

// File: rtl/i2s_simul_rx.sv
module i2s_simul_rx #(
    parameter int WORD_W = i2s_simul_pkg::SAMPLE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bck_rise_i,
    input  logic              ws_i,
    input  logic              sd_i,
    output logic              pair_vld_o,
    output logic [WORD_W-1:0] pair_l_o,
    output logic [WORD_W-1:0] pair_r_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

    logic              ws_prev_q;
    logic              have_left_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] left_q;
    logic [WORD_W-1:0] acc_nxt;
    logic              bit_in;

    // sign bit flipped on arrival: two's complement to offset binary
    always_comb begin
        bit_in  = (cnt_q == '0) ? ~sd_i : sd_i;
        acc_nxt = (cnt_q < CNT_FULL) ? {acc_q[WORD_W-2:0], bit_in} : acc_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_prev_q   <= 1'b1;
            have_left_q <= 1'b0;
            cnt_q       <= CNT_FULL;
            acc_q       <= '0;
            left_q      <= '0;
            pair_l_o    <= '0;
            pair_r_o    <= '0;
            pair_vld_o  <= 1'b0;
        end else begin
            pair_vld_o <= 1'b0;
            if (bck_rise_i) begin
                acc_q     <= acc_nxt;
                ws_prev_q <= ws_i;
                if (ws_i != ws_prev_q) begin
                    // the bit on this edge still belongs to the old slot
                    cnt_q <= '0;
                    if (!ws_prev_q) begin
                        left_q      <= acc_nxt;
                        have_left_q <= 1'b1;
                    end else if (have_left_q) begin
                        pair_l_o    <= left_q;
                        pair_r_o    <= acc_nxt;
                        pair_vld_o  <= 1'b1;
                        have_left_q <= 1'b0;
                    end
                end else if (cnt_q < CNT_FULL) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assert_cnt_saturates_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_FULL);

    assert_pair_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pair_vld_o |=> !pair_vld_o);

endmodule

// File: rtl/i2s_simul_tx.sv
module i2s_simul_tx
    import i2s_simul_pkg::*;
#(
    parameter int WORD_W = SAMPLE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bck_rise_i,
    input  logic              bck_fall_i,
    input  logic              pair_vld_i,
    input  logic [WORD_W-1:0] pair_l_i,
    input  logic [WORD_W-1:0] pair_r_i,
    output logic              dac_bck_o,
    output logic              dac_le_o,
    output logic              dac_dl_o,
    output logic              dac_dr_o
);
    localparam int NB_W = $clog2(WORD_W + 1);
    localparam logic [NB_W-1:0] NB_LAST = NB_W'(WORD_W);

    tx_state_t         st_q, st_d;
    logic [NB_W-1:0]   nbit_q;
    logic [WORD_W-1:0] shl_q, shr_q;
    logic              word_sent;

    assign word_sent = (nbit_q == NB_LAST) && !dac_bck_o;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TX_IDLE:  if (pair_vld_i) st_d = TX_SHIFT;
            TX_SHIFT: if (word_sent)  st_d = TX_LATCH;
            TX_LATCH: if (bck_rise_i) st_d = TX_IDLE;
            default:  st_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TX_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_bck_o <= 1'b1;
            dac_le_o  <= 1'b1;
            dac_dl_o  <= 1'b0;
            dac_dr_o  <= 1'b0;
            nbit_q    <= '0;
            shl_q     <= '0;
            shr_q     <= '0;
        end else begin
            dac_le_o <= (st_d != TX_SHIFT);
            unique case (st_q)
                TX_IDLE: begin
                    if (pair_vld_i) begin
                        shl_q  <= pair_l_i;
                        shr_q  <= pair_r_i;
                        nbit_q <= '0;
                    end
                end
                TX_SHIFT: begin
                    if (bck_rise_i && nbit_q != NB_LAST) begin
                        dac_dl_o  <= shl_q[WORD_W-1];
                        dac_dr_o  <= shr_q[WORD_W-1];
                        shl_q     <= {shl_q[WORD_W-2:0], 1'b0};
                        shr_q     <= {shr_q[WORD_W-2:0], 1'b0};
                        nbit_q    <= nbit_q + 1'b1;
                        dac_bck_o <= 1'b1;
                    end else if (bck_fall_i && nbit_q != '0) begin
                        dac_bck_o <= 1'b0;
                    end
                end
                TX_LATCH: begin
                    if (bck_rise_i) dac_bck_o <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assert_clk_parked_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_le_o && dac_bck_o) |=> dac_bck_o);

    assert_bit_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        nbit_q <= NB_LAST);

    assert_data_moves_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(dac_dl_o) || !$stable(dac_dr_o)) |-> (dac_bck_o && !dac_le_o));

    assert_latch_after_full_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_le_o) |-> (nbit_q == NB_LAST && !dac_bck_o));

endmodule

// File: rtl/i2s_simul_fmt.sv
module i2s_simul_fmt #(
    parameter int WORD_W      = i2s_simul_pkg::SAMPLE_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bck_i,
    input  logic ws_i,
    input  logic sd_i,
    output logic dac_bck_o,
    output logic dac_le_o,
    output logic dac_dl_o,
    output logic dac_dr_o
);
    logic              bck_rise, bck_fall, ws_s, sd_s;
    logic              pair_vld;
    logic [WORD_W-1:0] pair_l, pair_r;

    i2s_simul_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bck_i      (bck_i),
        .ws_i       (ws_i),
        .sd_i       (sd_i),
        .bck_rise_o (bck_rise),
        .bck_fall_o (bck_fall),
        .ws_o       (ws_s),
        .sd_o       (sd_s)
    );

    i2s_simul_rx #(.WORD_W(WORD_W)) rx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bck_rise_i (bck_rise),
        .ws_i       (ws_s),
        .sd_i       (sd_s),
        .pair_vld_o (pair_vld),
        .pair_l_o   (pair_l),
        .pair_r_o   (pair_r)
    );

    i2s_simul_tx #(.WORD_W(WORD_W)) tx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bck_rise_i (bck_rise),
        .bck_fall_i (bck_fall),
        .pair_vld_i (pair_vld),
        .pair_l_i   (pair_l),
        .pair_r_i   (pair_r),
        .dac_bck_o  (dac_bck_o),
        .dac_le_o   (dac_le_o),
        .dac_dl_o   (dac_dl_o),
        .dac_dr_o   (dac_dr_o)
    );

endmodule

// File: tb/i2s_simul_fmt_tb.sv
module i2s_simul_fmt_tb_top;
    localparam int NFR = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bck = 1'b1, ws = 1'b1, sd = 1'b0;
    logic dac_bck, dac_le, dac_dl, dac_dr;

    int errs = 0, checks = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit monitor_on = 1'b0;

    logic [15:0] smp_l [NFR];
    logic [15:0] smp_r [NFR];
    int          wid   [NFR];

    always #4 clk = ~clk;

    i2s_simul_fmt dut_i (
        .clk(clk), .rst_n(rst_n), .bck_i(bck), .ws_i(ws), .sd_i(sd),
        .dac_bck_o(dac_bck), .dac_le_o(dac_le), .dac_dl_o(dac_dl), .dac_dr_o(dac_dr)
    );

    function automatic logic [15:0] to_offset(input logic [15:0] s);
        return s ^ 16'h8000;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic send_bit(input logic w, input logic b);
        @(negedge clk);
        bck = 1'b0; ws = w; sd = b;
        repeat (4) @(negedge clk);
        bck = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // word select changes one bit before the next slot's MSB
    task automatic send_slot(input logic ch, input logic [15:0] w, input int width);
        for (int j = 0; j < width; j++) begin
            logic b;
            b = (j < 16) ? w[15-j] : 1'($urandom);
            send_bit((j == width - 1) ? ~ch : ch, b);
        end
    endtask

    // DAC model and port checks, sampled on the falling system clock edge
    logic        p_bck = 1'b1, p_le = 1'b1, p_dl = 1'b0, p_dr = 1'b0;
    logic [15:0] sr_l = '0, sr_r = '0;
    int          falls = 0, idx = 0, le_rise_cyc = 0;
    bit          le_seen = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (monitor_on) begin
            if ((dac_dl !== p_dl || dac_dr !== p_dr) && dac_bck !== 1'b1)
                check(1'b0, "R5 data moved while gated clock low", int'(dac_bck), 1);
            if (p_bck && !dac_bck) begin
                sr_l = {sr_l[14:0], dac_dl};
                sr_r = {sr_r[14:0], dac_dr};
                falls++;
                if (dac_le) check(1'b0, "R4 clock fell outside window", int'(dac_le), 0);
            end
            if (p_le && !dac_le) begin
                check(dac_bck === 1'b1, "R4 clock high at window open", int'(dac_bck), 1);
                if (le_seen)
                    check(cyc - le_rise_cyc >= 8, "R6 strobe high time", cyc - le_rise_cyc, 8);
                falls = 0;
            end
            if (!p_le && dac_le) begin
                le_seen = 1'b1;
                le_rise_cyc = cyc;
                check(falls == 16, "R4,R6 clock falls in window", falls, 16);
                if (idx < NFR) begin
                    // R7: frames with wide slots carry junk past bit 16
                    check(sr_l == to_offset(smp_l[idx]), "R2,R8,R7 left word",
                          int'(sr_l), int'(to_offset(smp_l[idx])));
                    check(sr_r == to_offset(smp_r[idx]), "R3,R2,R7 right word",
                          int'(sr_r), int'(to_offset(smp_r[idx])));
                end
                idx++;
            end
        end
        p_bck = dac_bck; p_le = dac_le; p_dl = dac_dl; p_dr = dac_dr;
    end

    initial begin
        void'($urandom(32'd20240611));
        smp_l[0] = 16'h8000; smp_r[0] = 16'h7FFF;
        smp_l[1] = 16'h0000; smp_r[1] = 16'hFFFF;
        smp_l[2] = 16'h1234; smp_r[2] = 16'hEDCB;
        smp_l[3] = 16'h0001; smp_r[3] = 16'h8001;
        smp_l[4] = 16'hAAAA; smp_r[4] = 16'h5555;
        for (int f = 0; f < 5; f++) wid[f] = 16;
        wid[3] = 32;
        for (int f = 5; f < NFR; f++) begin
            smp_l[f] = 16'($urandom);
            smp_r[f] = 16'($urandom);
            wid[f]   = 16 + 8 * int'($urandom % 3);
        end

        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(dac_bck === 1'b1, "R1 gated clock after reset", int'(dac_bck), 1);
        check(dac_le === 1'b1, "R1 strobe after reset", int'(dac_le), 1);
        check(dac_dl === 1'b0 && dac_dr === 1'b0, "R1 data after reset",
              int'({dac_dl, dac_dr}), 0);
        monitor_on = 1'b1;

        send_slot(1'b1, 16'h0000, 4);
        for (int f = 0; f < NFR; f++) begin
            send_slot(1'b0, smp_l[f], wid[f]);
            send_slot(1'b1, smp_r[f], wid[f]);
        end
        for (int f = 0; f < 2; f++) begin
            send_slot(1'b0, 16'h0000, 16);
            send_slot(1'b1, 16'h0000, 16);
        end
        repeat (40) @(negedge clk);
        check(idx >= NFR, "R3 every frame latched", idx, NFR);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule